// File: doc/BRIEF.md
# Master Audio Serial Frame Generator

The block derives three framing clocks from a single master clock and serializes a stereo pair of 16-bit samples onto one data line. The bit clock runs at a quarter of the master clock rate. A left/right clock marks 64-bit frames made of two 32-bit fields, and a word clock marks where the sample word sits inside each field. The clock edge on which data changes can be selected. Four data placements are available: left-justified, left-justified with a one-bit delay, right-justified, and right-justified with MSB delay. In the last of these the word clock is a single bit-clock-long pulse, and the LSB of each word spills into the first bit slot of the following field.

New samples are offered on a parallel port together with a valid strobe. A strobe is accepted only during the last eighth of a frame. Accepted samples are transmitted from the start of the next frame. This leaves the frame in flight undisturbed, and it gives the spilled LSB a stable source.

Top module: `aud_frame_gen`

## Requirements
- R1: A frame is 64 bit slots. `lrck_o` is high for slots 0..31 (left field) and low for slots 32..63, and it changes only at the start of slot 0 or slot 32.
- R2: Each bit slot lasts 4 `clk_i` cycles, so one frame spans 256 `clk_i` cycles. `bclk_o` is high for half of each slot and low for the other half.
- R3: With `bclk_pol_i`=1, `bclk_o` falls at the start of each slot, where `data_o` changes, and rises at mid-slot, where data is sampled. With `bclk_pol_i`=0 both edges are inverted.
- R4: The format is {`rjust_i`,`msb_dly_i`}. With 00 the word occupies field slots 0..15, and with 01 it occupies field slots 1..16. In both cases `wclk_o` is high exactly during those slots.
- R5: With format 10 the word occupies field slots 16..31, and `wclk_o` is high exactly during those slots.
- R6: With format 11, `wclk_o` is high only in field slot 16, for one bit slot. The MSB is in field slot 17, word bits 14..1 follow in slots 18..31, and bit 0 is sent in slot 0 of the next field.
- R7: The left word is sent in the left field and the right word in the right field, MSB first. `data_o` is 0 in every slot that carries no word bit. The spilled bit in the left field's slot 0 is the previous frame's right LSB.
- R8: `smp_valid_i` captures `smp_left_i`/`smp_right_i` only when it is sampled during frame slots 56..63. A strobe at any other time has no effect.
- R9: Captured samples begin transmission at slot 0 of the frame that follows the capture.
- R10: While `rst_ni` is low, `bclk_o`, `lrck_o`, `wclk_o` and `data_o` are 0 and the stored samples are cleared. On the first clock after release, the outputs show slot 0 of a left field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_pol_i | input | 1 | Bit clock polarity select |
| rjust_i | input | 1 | Right-justified placement select |
| msb_dly_i | input | 1 | One-slot MSB delay select |
| smp_valid_i | input | 1 | Sample strobe |
| smp_left_i | input | 16 | Left channel sample |
| smp_right_i | input | 16 | Right channel sample |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Left/right clock |
| wclk_o | output | 1 | Word clock |
| data_o | output | 1 | Serial data |

## Verification
Every cycle, the assertions check edge placement. The left/right clock may move only at field boundaries, the bit clock edges must fall at the phases the polarity select implies, data may change only at slot starts, and the delayed-mode word pulse must rise at field slot 16 and fall one slot later. They also check that stored samples change only through an in-window strobe and that they move to the transmit registers only at frame start. Only the bench's scenarios can show the actual bit values in each slot for every format. The same holds for the spilled LSB coming from the correct word, for an out-of-window strobe leaving the transmitted word untouched, and for framing restarting cleanly after a reset in mid-run.

// File: rtl/aud_frame_pkg.sv
package aud_frame_pkg;
  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_DLY = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_RJD = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_frame_cnt.sv
module aud_frame_cnt #(
  parameter int DIV_W  = 2,
  parameter int SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DIV_W-1:0]  ph_o,
  output logic [SLOT_W-1:0] slot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_o   <= '0;
      slot_o <= '0;
    end else begin
      ph_o <= ph_o + 1'b1;
      if (ph_o == '1) slot_o <= slot_o + 1'b1;
    end
  end
endmodule

// File: rtl/aud_sample_bank.sv
module aud_sample_bank #(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 2,
  parameter int SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  ph_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic [WORD_W-1:0] act_l_o,
  output logic [WORD_W-1:0] act_r_o,
  output logic              spill_o
);
  localparam int FRAME     = 1 << SLOT_W;
  localparam int WIN_START = FRAME - FRAME / 8;

  logic [WORD_W-1:0] hold_l, hold_r;
  logic in_win, field_end;

  assign in_win    = slot_i >= SLOT_W'(WIN_START);
  assign field_end = (ph_i == '1) && (slot_i[SLOT_W-2:0] == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l  <= '0;
      hold_r  <= '0;
      act_l_o <= '0;
      act_r_o <= '0;
      spill_o <= 1'b0;
    end else begin
      if (valid_i && in_win) begin
        hold_l <= left_i;
        hold_r <= right_i;
      end
      if (field_end) begin
        // LSB of the word just finished is sent in slot 0 of the next field
        spill_o <= slot_i[SLOT_W-1] ? act_r_o[0] : act_l_o[0];
        if (slot_i[SLOT_W-1]) begin
          act_l_o <= hold_l;
          act_r_o <= hold_r;
        end
      end
    end
  end

  // R8
  hold_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({hold_l, hold_r}) |-> ($past(valid_i) && $past(in_win)));

  // R9
  act_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({act_l_o, act_r_o}) |-> (slot_i == '0 && ph_i == '0));
endmodule

// File: rtl/aud_frame_ser.sv
module aud_frame_ser
  import aud_frame_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 2,
  parameter int SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  ph_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  fmt_e              fmt_i,
  input  logic              pol_i,
  input  logic [WORD_W-1:0] act_l_i,
  input  logic [WORD_W-1:0] act_r_i,
  input  logic              spill_i,
  output logic              bclk_o,
  output logic              lrck_o,
  output logic              wclk_o,
  output logic              data_o
);
  localparam int FIELD  = 1 << (SLOT_W - 1);
  localparam int HALF   = 1 << (DIV_W - 1);
  localparam int ST_LJ  = 0;
  localparam int ST_DLY = 1;
  localparam int ST_RJ  = FIELD - WORD_W;
  localparam int ST_RJD = FIELD - WORD_W + 1;

  int                b, st;
  logic              in_rng, d_n, w_n;
  logic [WORD_W-1:0] word, sh;

  always_comb begin
    b    = int'(slot_i[SLOT_W-2:0]);
    word = slot_i[SLOT_W-1] ? act_r_i : act_l_i;
    unique case (fmt_i)
      FMT_LJ:  st = ST_LJ;
      FMT_DLY: st = ST_DLY;
      FMT_RJ:  st = ST_RJ;
      default: st = ST_RJD;
    endcase
    in_rng = (b >= st) && (b < st + WORD_W);
    sh     = '0;
    d_n    = 1'b0;
    if (in_rng) begin
      sh  = word >> (st + WORD_W - 1 - b);
      d_n = sh[0];
    end
    if (fmt_i == FMT_RJD && b == 0) d_n = spill_i;
    w_n = (fmt_i == FMT_RJD) ? (b == ST_RJD - 1) : in_rng;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_o <= 1'b0;
      lrck_o <= 1'b0;
      wclk_o <= 1'b0;
      data_o <= 1'b0;
    end else begin
      bclk_o <= pol_i ? ph_i[DIV_W-1] : ~ph_i[DIV_W-1];
      lrck_o <= ~slot_i[SLOT_W-1];
      wclk_o <= w_n;
      data_o <= d_n;
    end
  end

  // settings behind the output register, used only by the checks below
  fmt_e fmt_q, fmt_qq;
  logic pol_q, pol_qq;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= FMT_LJ;
      fmt_qq <= FMT_LJ;
      pol_q  <= 1'b0;
      pol_qq <= 1'b0;
    end else begin
      fmt_q  <= fmt_i;
      fmt_qq <= fmt_q;
      pol_q  <= pol_i;
      pol_qq <= pol_q;
    end
  end

  // R1
  lrck_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrck_o) |-> (ph_i == DIV_W'(1) && slot_i[SLOT_W-2:0] == '0));

  // R3
  bclk_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_q == pol_qq && !$stable(bclk_o)) |->
      (ph_i == ((bclk_o ^ ~pol_q) ? DIV_W'(HALF + 1) : DIV_W'(1))));

  // R6
  wclk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q == FMT_RJD && fmt_qq == FMT_RJD && $rose(wclk_o)) |->
      (ph_i == DIV_W'(1) && int'(slot_i[SLOT_W-2:0]) == ST_RJD - 1));

  // R6
  wclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q == FMT_RJD && fmt_qq == FMT_RJD && $fell(wclk_o)) |->
      (ph_i == DIV_W'(1) && int'(slot_i[SLOT_W-2:0]) == ST_RJD));

  // R7
  data_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q == fmt_qq && !$stable(data_o)) |-> (ph_i == DIV_W'(1)));

  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert ({bclk_o, lrck_o, wclk_o, data_o} == 4'b0000);
    end
  end
endmodule

// File: rtl/aud_frame_gen.sv
module aud_frame_gen
  import aud_frame_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 2,
  parameter int SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_pol_i,
  input  logic              rjust_i,
  input  logic              msb_dly_i,
  input  logic              smp_valid_i,
  input  logic [WORD_W-1:0] smp_left_i,
  input  logic [WORD_W-1:0] smp_right_i,
  output logic              bclk_o,
  output logic              lrck_o,
  output logic              wclk_o,
  output logic              data_o
);
  logic [DIV_W-1:0]  ph;
  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] act_l, act_r;
  logic              spill;
  fmt_e              fmt;

  assign fmt = fmt_e'({rjust_i, msb_dly_i});

  aud_frame_cnt #(.DIV_W(DIV_W), .SLOT_W(SLOT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ph_o   (ph),
    .slot_o (slot)
  );

  aud_sample_bank #(.WORD_W(WORD_W), .DIV_W(DIV_W), .SLOT_W(SLOT_W)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_i    (ph),
    .slot_i  (slot),
    .valid_i (smp_valid_i),
    .left_i  (smp_left_i),
    .right_i (smp_right_i),
    .act_l_o (act_l),
    .act_r_o (act_r),
    .spill_o (spill)
  );

  aud_frame_ser #(.WORD_W(WORD_W), .DIV_W(DIV_W), .SLOT_W(SLOT_W)) i_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_i    (ph),
    .slot_i  (slot),
    .fmt_i   (fmt),
    .pol_i   (bclk_pol_i),
    .act_l_i (act_l),
    .act_r_i (act_r),
    .spill_i (spill),
    .bclk_o  (bclk_o),
    .lrck_o  (lrck_o),
    .wclk_o  (wclk_o),
    .data_o  (data_o)
  );
endmodule

// File: tb/test_aud_frame_gen.sv
module test_aud_frame_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk_pol_i = 1'b1;
  logic        rjust_i = 1'b0;
  logic        msb_dly_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_left_i = '0;
  logic [15:0] smp_right_i = '0;
  logic        bclk_o, lrck_o, wclk_o, data_o;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #5 clk_i = ~clk_i;

  aud_frame_gen i_aud_frame_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bclk_pol_i  (bclk_pol_i),
    .rjust_i     (rjust_i),
    .msb_dly_i   (msb_dly_i),
    .smp_valid_i (smp_valid_i),
    .smp_left_i  (smp_left_i),
    .smp_right_i (smp_right_i),
    .bclk_o      (bclk_o),
    .lrck_o      (lrck_o),
    .wclk_o      (wclk_o),
    .data_o      (data_o)
  );

  // ---------------- reference model built from the requirements ----------------
  logic [7:0]  m_g = '0;
  logic [15:0] m_hold_l = '0, m_hold_r = '0, m_act_l = '0, m_act_r = '0;
  logic        m_spill = 1'b0;
  logic        e_bclk = 1'b0, e_lrck = 1'b0, e_wclk = 1'b0, e_data = 1'b0;

  function automatic logic [1:0] exp_bits(input logic [1:0] fmt, input int b,
                                          input logic [15:0] w, input logic sp);
    int st;
    logic wc, d;
    case (fmt)
      2'b00: st = 0;   // R4
      2'b01: st = 1;   // R4
      2'b10: st = 16;  // R5
      default: st = 17; // R6
    endcase
    d = 1'b0;
    if (b >= st && b < st + 16) d = w[15 - (b - st)];
    if (fmt == 2'b11 && b == 0) d = sp;
    wc = (fmt == 2'b11) ? (b == 16) : (b >= st && b < st + 16);
    return {wc, d};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_g <= '0; m_hold_l <= '0; m_hold_r <= '0; m_act_l <= '0; m_act_r <= '0;
      m_spill <= 1'b0;
      e_bclk <= 1'b0; e_lrck <= 1'b0; e_wclk <= 1'b0; e_data <= 1'b0;
    end else begin
      logic [1:0] ph, wd;
      logic [5:0] slot;
      logic       lf;
      ph   = m_g[1:0];
      slot = m_g[7:2];
      lf   = (slot < 6'd32);
      e_bclk <= bclk_pol_i ? (ph >= 2'd2) : (ph < 2'd2);
      e_lrck <= lf;
      wd = exp_bits({rjust_i, msb_dly_i}, int'(slot[4:0]), lf ? m_act_l : m_act_r, m_spill);
      e_wclk <= wd[1];
      e_data <= wd[0];
      if (smp_valid_i && slot >= 6'd56) begin
        m_hold_l <= smp_left_i;
        m_hold_r <= smp_right_i;
      end
      if (ph == 2'd3 && slot[4:0] == 5'd31) begin
        m_spill <= lf ? m_act_l[0] : m_act_r[0];
        if (!lf) begin
          m_act_l <= m_hold_l;
          m_act_r <= m_hold_r;
        end
      end
      m_g <= m_g + 8'd1;
    end
  end

  // continuous comparison against the model
  always @(negedge clk_i) begin
    if (!done) begin
      n_checks += 4;
      if (bclk_o !== e_bclk) begin
        n_errs++; $display("FAIL R2 R3 bclk act=%b exp=%b t=%0t", bclk_o, e_bclk, $time);
      end
      if (lrck_o !== e_lrck) begin
        n_errs++; $display("FAIL R1 lrck act=%b exp=%b t=%0t", lrck_o, e_lrck, $time);
      end
      if (wclk_o !== e_wclk) begin
        n_errs++; $display("FAIL R4 R5 R6 wclk act=%b exp=%b t=%0t", wclk_o, e_wclk, $time);
      end
      if (data_o !== e_data) begin
        n_errs++; $display("FAIL R7 R9 data act=%b exp=%b t=%0t", data_o, e_data, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic strobe_at(input int slot, input logic [15:0] l, input logic [15:0] r);
    @(negedge clk_i);
    while (!(int'(m_g[7:2]) == slot && m_g[1:0] == 2'd0)) @(negedge clk_i);
    smp_valid_i = 1'b1; smp_left_i = l; smp_right_i = r;
    @(negedge clk_i);
    smp_valid_i = 1'b0;
  endtask

  task automatic wait_lrck_rise();
    @(posedge lrck_o);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  endtask

  // {rjust, msb_dly, pol, left, right}
  localparam logic [34:0] VEC [8] = '{
    {2'b00, 1'b1, 16'hA5C3, 16'h3C5A},
    {2'b00, 1'b0, 16'h8001, 16'h7FFE},
    {2'b01, 1'b1, 16'hFFFF, 16'h0000},
    {2'b01, 1'b0, 16'h1357, 16'h9BDF},
    {2'b10, 1'b1, 16'h0F0F, 16'hF0F0},
    {2'b10, 1'b0, 16'hC001, 16'h0003},
    {2'b11, 1'b1, 16'h8003, 16'h4001},
    {2'b11, 1'b0, 16'h6D2B, 16'hB4D5}
  };

  initial begin
    #1ms;
    n_errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    // R10: outputs quiet in reset
    repeat (3) @(negedge clk_i);
    chk({bclk_o, lrck_o, wclk_o, data_o} == 4'b0, "R10 reset outputs",
        {12'b0, bclk_o, lrck_o, wclk_o, data_o}, 16'h0);
    #2 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(lrck_o == 1'b1 && data_o == 1'b0, "R10 first left field", {14'b0, lrck_o, data_o}, 16'h2);

    // table walk: all formats, both polarities
    for (int i = 0; i < 8; i++) begin
      {rjust_i, msb_dly_i, bclk_pol_i} = VEC[i][34:32];
      strobe_at(58, VEC[i][31:16], VEC[i][15:0]);
      wait_lrck_rise();
      wait_lrck_rise();
    end

    // R9 then R8: out-of-window strobe leaves transmitted word unchanged
    {rjust_i, msb_dly_i, bclk_pol_i} = 3'b001;
    strobe_at(58, 16'h1234, 16'hFEDC);
    wait_lrck_rise();
    w = '0;
    for (int k = 0; k < 16; k++) begin
      w = {w[14:0], data_o};
      repeat (4) @(negedge clk_i);
    end
    chk(w == 16'h1234, "R9 left word after capture", w, 16'h1234);
    strobe_at(10, 16'hDEAD, 16'hBEEF);
    wait_lrck_rise();
    w = '0;
    for (int k = 0; k < 16; k++) begin
      w = {w[14:0], data_o};
      repeat (4) @(negedge clk_i);
    end
    chk(w == 16'h1234, "R8 strobe outside window ignored", w, 16'h1234);
    strobe_at(40, 16'hDEAD, 16'hBEEF);
    wait_lrck_rise();
    wait_lrck_rise();
    w = '0;
    for (int k = 0; k < 16; k++) begin
      w = {w[14:0], data_o};
      repeat (4) @(negedge clk_i);
    end
    chk(w == 16'h1234, "R8 strobe at slot 40 ignored", w, 16'h1234);

    // R6: delayed right-justified pulse, MSB at 17, LSB spills into right field slot 0
    {rjust_i, msb_dly_i, bclk_pol_i} = 3'b111;
    strobe_at(58, 16'hC3A5, 16'h5A3C);
    wait_lrck_rise();
    repeat (16 * 4) @(negedge clk_i);
    chk(wclk_o == 1'b1, "R6 wclk high in slot 16", {15'b0, wclk_o}, 16'h1);
    repeat (4) @(negedge clk_i);
    chk(wclk_o == 1'b0, "R6 wclk low in slot 17", {15'b0, wclk_o}, 16'h0);
    w = '0;
    for (int k = 0; k < 15; k++) begin
      w = {w[14:0], data_o};
      repeat (4) @(negedge clk_i);
    end
    chk(lrck_o == 1'b0, "R1 right field after slot 31", {15'b0, lrck_o}, 16'h0);
    w = {w[14:0], data_o};
    chk(w == 16'hC3A5, "R6 left word with spilled LSB", w, 16'hC3A5);

    // R10: reset in mid-run, then clean restart
    repeat (37) @(negedge clk_i);
    #2 rst_ni = 1'b0;
    @(negedge clk_i);
    chk({bclk_o, lrck_o, wclk_o, data_o} == 4'b0, "R10 mid-run reset outputs",
        {12'b0, bclk_o, lrck_o, wclk_o, data_o}, 16'h0);
    {rjust_i, msb_dly_i, bclk_pol_i} = 3'b000;
    #2 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(lrck_o == 1'b1 && wclk_o == 1'b1 && bclk_o == 1'b1 && data_o == 1'b0,
        "R10 restart at left slot 0", {12'b0, bclk_o, lrck_o, wclk_o, data_o}, 16'hE);
    wait_lrck_rise();
    chk(data_o == 1'b0, "R10 samples cleared", {15'b0, data_o}, 16'h0);
    finish_run();
  end
endmodule